// File: doc/BRIEF.md
# Dual-Format MDIO Management Controller

This block lets a host talk to an external Ethernet PHY over the two-wire management bus. The host writes a command word into a command register; the controller turns it into a clause-22 serial frame, generates the management clock, drives the data line while it owns it, releases it for the PHY's reply and samples the answer. When the frame ends, the trigger bit in the command register drops and read results land in the data register.

Two command word layouts are accepted, chosen by one bit of a feature register. In the packed layout the command word carries everything, write data included. In the legacy layout the command word holds the addresses and two request bits, write data comes from the data register, and read data returns in the upper half of the data register instead of the lower half. Both layouts feed the same serial engine, so the frame timing is identical.

Register map (word addresses): 0 = command, 1 = data, 2 = feature (bit 0 = packed layout select, other bits read as zero).

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Packed layout: command bits [4:0] = register address, [9:5] = PHY address, [11:10] = opcode (01 write, 10 read), bit 12 = clause-22 enable, bit 15 = go, [31:16] = write data; a write with go, enable and opcode 01 sends a write frame carrying those fields.
- R2: Packed layout read (opcode 10) stores the 16 returned bits in data register [15:0] and zeros [31:16].
- R3: Packed layout with opcode 00 or 11 sends no frame and the go bit reads back as 0.
- R4: Packed layout with bit 12 clear sends no frame and the go bit reads back as 0.
- R5: Packed layout with bit 15 clear sends no frame.
- R6: The trigger bit (packed bit 15, legacy bit 27 or 26) reads 1 for the whole frame and 0 after it; all other command bits keep the written value.
- R7: Feature register bit 0 is writable, reads back as written and resets to 0 (legacy layout).
- R8: Legacy layout: bit 27 requests a write using data register [15:0], PHY address in bits [20:16], register address in bits [25:21].
- R9: Legacy layout: bit 26 requests a read; the result goes to data register [31:16] and [15:0] becomes zero.
- R10: Legacy layout with bits 27 and 26 both set performs the write; bit 26 reads back as 0.
- R11: Legacy layout with neither request bit set sends no frame.
- R12: Frame, MSB first, 64 bit periods: 32 ones, 01, opcode, PHY address, register address, turnaround 10 driven for a write or released for a read, 16 data bits; on a read the line is released from bit period 46 on.
- R13: The management clock has a period of CLK_DIV system clocks, starts low, rises mid-period and falls at each bit boundary; while idle it is low and the output enable is low.
- R14: A command register write while a frame is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 2 | Register read address |
| reg_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
Write and read frames are issued in both layouts against different PHY and register addresses, so a swapped address field, a wrong opcode or a read result placed in the wrong half shows up as a mismatch in the PHY model's decoded frame or the data register. Each rejected packed command (bad opcode, clause-22 enable clear, go clear), the legacy no-request and both-request words, and a command written mid-frame separate the launch conditions from each other. A per-clock model predicts the clock level, output enable, every driven bit and the busy flag, which separates turnaround and release timing errors from plain field errors.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int FRAME_BITS = 64;
  localparam int RELEASE_AT = 46;
  localparam int DATA_FIRST = 48;

  localparam int PK_GO    = 15;
  localparam int PK_C22   = 12;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam int LG_WREQ  = 27;
  localparam int LG_RREQ  = 26;

  localparam logic [1:0] A_CMD  = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_FEAT = 2'd2;

  typedef struct packed {
    logic        go;
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdat;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [31:0] w, input logic pk,
                                      input logic [31:0] dat);
    cmd_t c;
    c = '0;
    if (pk) begin
      c.phy   = w[9:5];
      c.regad = w[4:0];
      c.wdat  = w[31:16];
      c.rd    = (w[11:10] == OP_RD);
      c.go    = w[PK_GO] & w[PK_C22] & ((w[11:10] == OP_WR) | (w[11:10] == OP_RD));
    end else begin
      c.phy   = w[20:16];
      c.regad = w[25:21];
      c.wdat  = dat[15:0];
      c.rd    = ~w[LG_WREQ] & w[LG_RREQ];
      c.go    = w[LG_WREQ] | w[LG_RREQ];
    end
    return c;
  endfunction

  function automatic logic [63:0] build_frame(input cmd_t c);
    return {32'hFFFF_FFFF, 2'b01, (c.rd ? OP_RD : OP_WR), c.phy, c.regad,
            (c.rd ? 2'b11 : 2'b10), (c.rd ? 16'hFFFF : c.wdat)};
  endfunction

  function automatic logic [31:0] stored_word(input logic [31:0] w, input logic pk,
                                              input cmd_t c);
    logic [31:0] r;
    r = w;
    if (pk && !c.go) r[PK_GO] = 1'b0;
    if (!pk && w[LG_WREQ]) r[LG_RREQ] = 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] retire_word(input logic [31:0] w, input logic pk);
    logic [31:0] r;
    r = w;
    if (pk) r[PK_GO] = 1'b0;
    else begin
      r[LG_WREQ] = 1'b0;
      r[LG_RREQ] = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [31:0] place_read(input logic pk, input logic [15:0] d);
    return pk ? {16'h0000, d} : {d, 16'h0000};
  endfunction

endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
  parameter int HALF = 4,
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  generate
    if (HALF == 1) begin : g_every
      assign tick = en;
    end else begin : g_count
      localparam logic [CW-1:0] TOP = CW'(HALF - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt_q <= '0;
        else if (cnt_q == TOP) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick = en & (cnt_q == TOP);
    end
  endgenerate
endmodule

// File: rtl/mdio_cmd_decode.sv
module mdio_cmd_decode
  import mdio_mgmt_pkg::*;
(
  input  logic [31:0] word,
  input  logic        pk,
  input  logic [31:0] dat,
  output cmd_t        cmd,
  output logic [31:0] keep_word,
  output logic [63:0] frame
);
  always_comb begin
    cmd       = decode_cmd(word, pk, dat);
    keep_word = stored_word(word, pk, cmd);
    frame     = build_frame(cmd);
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
  parameter int NBITS   = 64,
  parameter int REL_AT  = 46,
  parameter int DAT_AT  = 48,
  localparam int IW = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_rd,
  input  logic [NBITS-1:0] start_frame,
  input  logic             tick,
  input  logic             mdio_i,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             busy,
  output logic             run_rd,
  output logic             rise_ev,
  output logic             fall_ev,
  output logic             done_ev,
  output logic [IW-1:0]    bit_idx,
  output logic [15:0]      rd_data
);
  localparam logic [IW-1:0] LAST = IW'(NBITS - 1);
  localparam logic [IW-1:0] REL  = IW'(REL_AT);
  localparam logic [IW-1:0] DAT  = IW'(DAT_AT);

  logic             busy_q, mdc_q, rd_q;
  logic [IW-1:0]    idx_q;
  logic [NBITS-1:0] sh_q;
  logic [15:0]      cap_q;

  assign rise_ev = busy_q & tick & ~mdc_q;
  assign fall_ev = busy_q & tick & mdc_q;
  assign done_ev = fall_ev & (idx_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mdc_q  <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      cap_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      mdc_q  <= 1'b0;
      rd_q   <= start_rd;
      idx_q  <= '0;
      sh_q   <= start_frame;
    end else begin
      if (rise_ev) begin
        mdc_q <= 1'b1;
        if (rd_q && idx_q >= DAT) cap_q <= {cap_q[14:0], mdio_i};
      end
      if (fall_ev) begin
        mdc_q <= 1'b0;
        if (idx_q == LAST) busy_q <= 1'b0;
        else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= {sh_q[NBITS-2:0], 1'b0};
        end
      end
    end
  end

  assign mdc     = mdc_q;
  assign busy    = busy_q;
  assign run_rd  = rd_q;
  assign bit_idx = idx_q;
  assign rd_data = cap_q;
  assign mdio_o  = busy_q & sh_q[NBITS-1];
  assign mdio_oe = busy_q & (~rd_q | (idx_q < REL));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int CLK_DIV = 8,
  localparam int HALF = CLK_DIV / 2,
  localparam int IW = $clog2(FRAME_BITS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_waddr,
  input  logic [31:0] reg_wdata,
  input  logic [1:0]  reg_raddr,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [31:0] cmd_q, dat_q;
  logic        pk_q, run_pk_q;

  cmd_t        dec;
  logic [31:0] keep_word;
  logic [63:0] dec_frame;

  logic          eng_busy, eng_run_rd, eng_rise, eng_fall, eng_done, tick;
  logic [IW-1:0] eng_idx;
  logic [15:0]   eng_rd;
  logic          cmd_wr, launch;

  mdio_cmd_decode u_dec (
    .word(reg_wdata), .pk(pk_q), .dat(dat_q),
    .cmd(dec), .keep_word(keep_word), .frame(dec_frame)
  );

  mdc_divider #(.HALF(HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .en(eng_busy), .tick(tick)
  );

  assign cmd_wr = reg_we & (reg_waddr == A_CMD);
  assign launch = cmd_wr & ~eng_busy & dec.go;

  mdio_frame_engine #(.NBITS(FRAME_BITS), .REL_AT(RELEASE_AT), .DAT_AT(DATA_FIRST)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(launch), .start_rd(dec.rd),
    .start_frame(dec_frame), .tick(tick), .mdio_i(mdio_i),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(eng_busy),
    .run_rd(eng_run_rd), .rise_ev(eng_rise), .fall_ev(eng_fall),
    .done_ev(eng_done), .bit_idx(eng_idx), .rd_data(eng_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      dat_q    <= '0;
      pk_q     <= 1'b0;
      run_pk_q <= 1'b0;
    end else begin
      if (cmd_wr && !eng_busy) begin
        cmd_q    <= keep_word;
        run_pk_q <= pk_q;
      end
      if (reg_we && reg_waddr == A_DATA) dat_q <= reg_wdata;
      if (reg_we && reg_waddr == A_FEAT) pk_q <= reg_wdata[0];
      if (eng_done) begin
        cmd_q <= retire_word(cmd_q, run_pk_q);
        if (eng_run_rd) dat_q <= place_read(run_pk_q, eng_rd);
      end
    end
  end

  always_comb begin
    case (reg_raddr)
      A_CMD:   reg_rdata = cmd_q;
      A_DATA:  reg_rdata = dat_q;
      A_FEAT:  reg_rdata = {31'd0, pk_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker #(
  parameter int IW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [1:0]    reg_waddr,
  input logic [31:0]   reg_wdata,
  input logic          pk,
  input logic          busy,
  input logic          mdc,
  input logic          mdio_o,
  input logic          mdio_oe,
  input logic [31:0]   cmd_q,
  input logic          done_ev,
  input logic          fall_ev,
  input logic          run_rd,
  input logic          run_pk,
  input logic [IW-1:0] bit_idx
);
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  p_busy_cmd_frozen_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_ev) |=> $stable(cmd_q));

  p_go_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_pk) |-> cmd_q[15]);

  p_go_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && run_pk) |=> (!busy && !cmd_q[15]));

  p_read_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_rd && bit_idx >= IW'(46)) |-> !mdio_oe);

  p_change_on_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $past(fall_ev));

  p_bad_op_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_waddr == 2'd0 && !busy && pk &&
     (reg_wdata[11:10] == 2'b00 || reg_wdata[11:10] == 2'b11)) |=> !busy);

  p_no_c22_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_waddr == 2'd0 && !busy && pk && !reg_wdata[12]) |=> !busy);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_checker #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
  .reg_wdata(reg_wdata), .pk(pk_q), .busy(eng_busy), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe), .cmd_q(cmd_q), .done_ev(eng_done),
  .fall_ev(eng_fall), .run_rd(eng_run_rd), .run_pk(run_pk_q), .bit_idx(eng_idx)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;
  localparam int FLEN = 64 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_waddr = 2'd0, reg_raddr = 2'd0;
  logic [31:0] reg_wdata = '0;
  wire [31:0] reg_rdata;
  wire mdc, mdio_o, mdio_oe;
  logic phy_en = 1'b0, phy_val = 1'b1;
  wire mdio_i = phy_en ? phy_val : 1'b1;
  wire line = mdio_oe ? mdio_o : mdio_i;

  always #5 clk = ~clk;

  mdio_mgmt_ctrl #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] init_val(input int k);
    return 16'(k * 16'h03A5) ^ 16'hC00F;
  endfunction

  // behavioural PHY
  logic [15:0] mem [1024];
  logic [63:0] cap = '0, oecap = '0;
  int nrise = 0, frames = 0;
  bit rd_flag = 0;
  logic [9:0] key = '0;
  logic [31:0] f_pre;
  logic [1:0] f_st, f_op, f_ta;
  logic [4:0] f_phy, f_reg;
  logic [15:0] f_dat;
  logic [63:0] f_oe;

  always @(posedge mdc) begin
    cap = {cap[62:0], line};
    oecap = {oecap[62:0], mdio_oe};
    nrise++;
    if (nrise == 36) rd_flag = (cap[1:0] == 2'b10);
    if (nrise == 46) key = cap[9:0];
    if (nrise == 64) begin
      frames++;
      f_pre = cap[63:32]; f_st = cap[31:30]; f_op = cap[29:28];
      f_phy = cap[27:23]; f_reg = cap[22:18]; f_ta = cap[17:16];
      f_dat = cap[15:0]; f_oe = oecap;
      if (f_op == 2'b01) mem[{f_phy, f_reg}] = f_dat;
      nrise = 0;
    end
  end

  always @(negedge mdc) begin
    if (rd_flag && nrise >= 47 && nrise <= 63) begin
      phy_en = 1'b1;
      phy_val = (nrise == 47) ? 1'b0 : mem[key][63 - nrise];
    end else begin
      phy_en = 1'b0;
      if (nrise == 0) rd_flag = 0;
    end
  end

  // per-clock reference model
  bit exp_launch = 0, exp_rdm = 0, cur_rd = 0;
  logic [63:0] exp_fr = '0, cur_fr = '0;
  logic [31:0] exp_mask = '0, cur_mask = '0;
  int remain = 0;

  always @(posedge clk) begin
    #1;
    cycles++;
    if (rst_n) begin
      if (exp_launch) begin
        remain = FLEN; cur_rd = exp_rdm; cur_fr = exp_fr; cur_mask = exp_mask;
        exp_launch = 0;
      end else if (remain > 0) remain--;
      begin
        int e, idx;
        bit oe_x;
        e = FLEN - remain;
        idx = e / DIV;
        oe_x = (remain > 0) && (!cur_rd || idx < 46);
        chk("R13 mdc level", 32'(mdc), 32'((remain > 0) && ((e / HALF) % 2 == 1)));
        chk("R12 output enable", 32'(mdio_oe), 32'(oe_x));
        if (oe_x) chk("R12 driven bit", 32'(mdio_o), 32'(cur_fr[63 - idx]));
        if (reg_raddr == 2'd0)
          chk("R6 trigger busy", 32'((reg_rdata & cur_mask) != 0), 32'(remain > 0));
      end
    end
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] pkw(input bit go, input bit c22, input logic [1:0] op,
                                      input logic [4:0] phy, input logic [4:0] ra,
                                      input logic [15:0] d);
    return {d, go, 2'b00, c22, op, phy, ra};
  endfunction

  function automatic logic [31:0] lgw(input bit wr, input bit rd, input logic [4:0] phy,
                                      input logic [4:0] ra);
    return {4'd0, wr, rd, ra, phy, 16'd0};
  endfunction

  function automatic logic [63:0] mkfr(input bit rd, input logic [4:0] phy,
                                       input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, ra, 2'b10, d};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input bit go,
                    input bit rd, input logic [63:0] fr, input logic [31:0] mask);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    if (go) begin
      exp_launch = 1; exp_rdm = rd; exp_fr = fr; exp_mask = mask;
    end
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_raddr = a;
    #1 v = reg_rdata;
    reg_raddr = 2'd0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (remain > 0 || exp_launch) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic frame_ok(input string req, input bit isrd, input int nf0);
    chk({req, " frame count"}, 32'(frames), 32'(nf0 + 1));
    chk("R12 preamble", f_pre, 32'hFFFF_FFFF);
    chk("R12 start code", 32'(f_st), 32'h1);
    chk({req, " opcode"}, 32'(f_op), isrd ? 32'h2 : 32'h1);
    chk("R12 turnaround", 32'(f_ta), 32'h2);
    chk("R12 oe span", f_oe[63:32] & f_oe[31:0],
        isrd ? 32'hFFFF_C000 & f_oe[31:0] & f_oe[63:32] : 32'hFFFF_FFFF);
    if (isrd) chk("R12 released", f_oe[17:0], 32'h0);
  endtask

  initial begin
    logic [31:0] v, w;
    int nf;
    for (int k = 0; k < 1024; k++) mem[k] = init_val(k);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd0, v); chk("R6 reset cmd", v, 32'h0);
    rd(2'd1, v); chk("R2 reset data", v, 32'h0);
    rd(2'd2, v); chk("R7 reset feature", v, 32'h0);
    chk("R13 idle mdc", 32'(mdc), 32'h0);
    chk("R13 idle oe", 32'(mdio_oe), 32'h0);

    // packed layout
    wr(2'd2, 32'hFFFF_FFFF, 0, 0, '0, '0);
    rd(2'd2, v); chk("R7 feature readback", v, 32'h1);

    nf = frames;
    w = pkw(1, 1, 2'b01, 5'd5, 5'd9, 16'hBEEF);
    wr(2'd0, w, 1, 0, mkfr(0, 5'd5, 5'd9, 16'hBEEF), 32'h0000_8000);
    wait_idle();
    frame_ok("R1", 0, nf);
    chk("R1 phy", 32'(f_phy), 32'd5);
    chk("R1 reg", 32'(f_reg), 32'd9);
    chk("R1 data", 32'(f_dat), 32'hBEEF);
    rd(2'd0, v); chk("R6 go cleared", v, w & ~32'h8000);

    wr(2'd1, 32'hFFFF_FFFF, 0, 0, '0, '0);
    nf = frames;
    wr(2'd0, pkw(1, 1, 2'b10, 5'd5, 5'd9, 16'h1234), 1, 1,
       mkfr(1, 5'd5, 5'd9, 16'h0), 32'h0000_8000);
    wait_idle();
    frame_ok("R2", 1, nf);
    rd(2'd1, v); chk("R2 read low half", v, 32'h0000_BEEF);

    nf = frames;
    wr(2'd0, pkw(1, 1, 2'b10, 5'd31, 5'd0, 16'h0), 1, 1,
       mkfr(1, 5'd31, 5'd0, 16'h0), 32'h0000_8000);
    wait_idle();
    frame_ok("R2", 1, nf);
    rd(2'd1, v); chk("R2 read other addr", v, {16'h0, init_val(31 * 32)});

    nf = frames;
    w = pkw(1, 1, 2'b00, 5'd1, 5'd2, 16'h5555);
    wr(2'd0, w, 0, 0, '0, '0);
    repeat (3 * DIV) @(negedge clk);
    rd(2'd0, v); chk("R3 op00 go low", v, w & ~32'h8000);
    w = pkw(1, 1, 2'b11, 5'd1, 5'd2, 16'h5555);
    wr(2'd0, w, 0, 0, '0, '0);
    repeat (3 * DIV) @(negedge clk);
    rd(2'd0, v); chk("R3 op11 go low", v, w & ~32'h8000);
    chk("R3 no frame", 32'(frames), 32'(nf));

    w = pkw(1, 0, 2'b01, 5'd1, 5'd2, 16'h5555);
    wr(2'd0, w, 0, 0, '0, '0);
    repeat (3 * DIV) @(negedge clk);
    rd(2'd0, v); chk("R4 go low", v, w & ~32'h8000);
    chk("R4 no frame", 32'(frames), 32'(nf));

    w = pkw(0, 1, 2'b01, 5'd1, 5'd2, 16'h5555);
    wr(2'd0, w, 0, 0, '0, '0);
    repeat (3 * DIV) @(negedge clk);
    rd(2'd0, v); chk("R5 word kept", v, w);
    chk("R5 no frame", 32'(frames), 32'(nf));

    nf = frames;
    w = pkw(1, 1, 2'b01, 5'd7, 5'd3, 16'hA001);
    wr(2'd0, w, 1, 0, mkfr(0, 5'd7, 5'd3, 16'hA001), 32'h0000_8000);
    repeat (20 * DIV) @(negedge clk);
    wr(2'd0, pkw(1, 1, 2'b10, 5'd9, 5'd9, 16'h0), 0, 0, '0, '0);
    rd(2'd0, v); chk("R14 cmd unchanged mid-frame", v, w);
    wait_idle();
    chk("R14 one frame", 32'(frames), 32'(nf + 1));
    chk("R14 phy", 32'(f_phy), 32'd7);
    chk("R14 data", 32'(f_dat), 32'hA001);

    // legacy layout
    wr(2'd2, 32'h0, 0, 0, '0, '0);
    rd(2'd2, v); chk("R7 feature cleared", v, 32'h0);
    wr(2'd1, 32'h1234_A5C3, 0, 0, '0, '0);
    nf = frames;
    w = lgw(1, 0, 5'd3, 5'd17);
    wr(2'd0, w, 1, 0, mkfr(0, 5'd3, 5'd17, 16'hA5C3), 32'h0800_0000);
    wait_idle();
    frame_ok("R8", 0, nf);
    chk("R8 phy", 32'(f_phy), 32'd3);
    chk("R8 reg", 32'(f_reg), 32'd17);
    chk("R8 data", 32'(f_dat), 32'hA5C3);
    rd(2'd0, v); chk("R8 request cleared", v, w & ~32'h0800_0000);

    nf = frames;
    w = lgw(0, 1, 5'd3, 5'd17);
    wr(2'd0, w, 1, 1, mkfr(1, 5'd3, 5'd17, 16'h0), 32'h0400_0000);
    wait_idle();
    frame_ok("R9", 1, nf);
    rd(2'd1, v); chk("R9 read high half", v, 32'hA5C3_0000);
    rd(2'd0, v); chk("R9 request cleared", v, w & ~32'h0400_0000);

    wr(2'd1, 32'h0000_0F0F, 0, 0, '0, '0);
    nf = frames;
    w = lgw(1, 1, 5'd12, 5'd4);
    wr(2'd0, w, 1, 0, mkfr(0, 5'd12, 5'd4, 16'h0F0F), 32'h0800_0000);
    rd(2'd0, v); chk("R10 read bit dropped", v & 32'h0C00_0000, 32'h0800_0000);
    wait_idle();
    frame_ok("R10", 0, nf);
    chk("R10 data", 32'(f_dat), 32'h0F0F);
    rd(2'd0, v); chk("R10 both cleared", v, w & ~32'h0C00_0000);

    nf = frames;
    wr(2'd0, lgw(0, 0, 5'd2, 5'd2), 0, 0, '0, '0);
    repeat (3 * DIV) @(negedge clk);
    chk("R11 no frame", 32'(frames), 32'(nf));
    rd(2'd1, v); chk("R11 data untouched", v, 32'h0000_0F0F);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule